// File: doc/BRIEF.md
# Speculative Load Snoop Invalidation Buffer

This block keeps a record of loads that have executed speculatively but have not yet retired. The pipeline inserts each load, in age order, when it executes. The insert carries the load's address and its age tag. Loads leave from the oldest end when the retire port fires.

In a multiprocessor, another core may write a line after a local load has already read it but before that load commits. The local load and everything that used its value would then hold a stale value. To catch this, every store observed from another processor is compared, at cache-line granularity, against all resident loads. When any resident load is hit, the block raises a one-cycle squash request one cycle later. The request carries the tag of the oldest hit load. The pipeline then re-executes that load and all younger work. The block drops the hit load and every younger entry in the same edge.

A parameter selects a second mode with no snooping at all. In that mode, each load is announced for re-execution as it retires. The retire port then presents the retiring load's tag and address.

Top module: `spec_load_snoop`

## Requirements
- R1: After reset the buffer is empty: `ld_ready` is 1 and `sq_valid` and `rx_valid` are 0.
- R2: In snoop mode (`REEXEC`=0), a snoop that hits a resident load sets `sq_valid` for the cycle after the snoop edge, with `sq_tag` equal to that load's tag. Otherwise `sq_valid` is 0.
- R3: A snoop hits a load when the two addresses agree in every bit above the low `LINE_OFF` offset bits. With `LINE_OFF`=6, address 0x0110 hits a load at 0x0100, but 0x0140 does not.
- R4: When several resident loads hit, `sq_tag` is the tag of the oldest of them, that is, the earliest inserted.
- R5: A squash removes the hit load and every younger entry from the buffer. Older entries stay and can still be hit by later snoops.
- R6: `ret_valid` removes the oldest entry, and a load being retired in the same cycle as a snoop is not compared. `ret_valid` on an empty buffer has no effect.
- R7: `ld_ready` is 0 while `DEPTH` loads are held. An insert offered while the buffer is full is discarded, and a later snoop to its line does not squash.
- R8: A load inserted in the same cycle as a snoop is not compared against that snoop. If that snoop hits an older load, the inserted load is discarded together with the flushed entries.
- R9: In re-execute mode (`REEXEC`=1), `sq_valid` stays 0 whatever is snooped. While `ret_valid` is 1 and the buffer is not empty, `rx_valid` is 1 in the same cycle, and `rx_tag`/`rx_addr` show the oldest load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Insert an executed load (ignored when full) |
| ld_addr | input | ADDR_W | Address read by the load |
| ld_tag | input | TAG_W | Age tag of the load |
| ld_ready | output | 1 | Buffer has room for an insert |
| ret_valid | input | 1 | Retire the oldest load |
| snp_valid | input | 1 | A store from another processor is observed |
| snp_addr | input | ADDR_W | Address written by that store |
| sq_valid | output | 1 | Squash request, one cycle after the hitting snoop |
| sq_tag | output | TAG_W | Tag of the oldest hit load |
| rx_valid | output | 1 | Re-execute the retiring load (re-execute mode only) |
| rx_tag | output | TAG_W | Tag of the retiring load |
| rx_addr | output | ADDR_W | Address of the retiring load |

## Verification
The bench builds two copies with `DEPTH`=4, `ADDR_W`=16, `TAG_W`=4 and `LINE_OFF`=6. One copy snoops and the other re-executes at retirement. A depth of four makes the full buffer, the discarded insert, and a squash that cuts a wrapped queue in its middle reachable within a few dozen cycles. A 64-byte line lets one address pair differ only in its offset and another differ only in its line. Both copies receive the same stimulus, so the re-execute copy shows at each step that no snoop pattern ever raises a squash.

// File: rtl/spec_load_snoop.sv
module spec_load_snoop #(
  parameter int ADDR_W   = 32,
  parameter int TAG_W    = 6,
  parameter int DEPTH    = 8,
  parameter int LINE_OFF = 6,
  parameter bit REEXEC   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [TAG_W-1:0]  ld_tag,
  output logic              ld_ready,
  input  logic              ret_valid,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              sq_valid,
  output logic [TAG_W-1:0]  sq_tag,
  output logic              rx_valid,
  output logic [TAG_W-1:0]  rx_tag,
  output logic [ADDR_W-1:0] rx_addr
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  cnt;

  logic              ins, ret;
  logic              hit;
  logic [PTR_W-1:0]  hit_off;
  logic [TAG_W-1:0]  hit_tag;

  assign ld_ready = (cnt != CNT_W'(DEPTH));
  assign ins      = ld_valid && ld_ready;
  assign ret      = ret_valid && (cnt != '0);

  assign rx_valid = REEXEC && ret;
  assign rx_tag   = tag_q[head];
  assign rx_addr  = addr_q[head];

  always_comb begin
    hit     = 1'b0;
    hit_off = '0;
    hit_tag = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PTR_W-1:0] idx;
      idx = head + PTR_W'(i);
      if (!REEXEC && snp_valid && !hit && (i < int'(cnt)) && !(i == 0 && ret) &&
          (((addr_q[idx] ^ snp_addr) >> LINE_OFF) == '0)) begin
        hit     = 1'b1;
        hit_off = PTR_W'(i);
        hit_tag = tag_q[idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      tail     <= '0;
      cnt      <= '0;
      sq_valid <= 1'b0;
      sq_tag   <= '0;
    end else begin
      sq_valid <= hit;
      sq_tag   <= hit ? hit_tag : '0;
      head     <= head + PTR_W'(ret);
      if (hit) begin
        tail <= head + hit_off;
        cnt  <= {1'b0, hit_off} - CNT_W'(ret);
      end else begin
        tail <= tail + PTR_W'(ins);
        cnt  <= cnt + CNT_W'(ins) - CNT_W'(ret);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && ins && !hit) begin
      addr_q[tail] <= ld_addr;
      tag_q[tail]  <= ld_tag;
    end
  end

  a_r2_squash_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |-> $past(snp_valid));

  a_r5_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |-> (cnt < $past(cnt)));

  a_r6_retire_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && cnt != '0 && !ld_valid) |=> (cnt < $past(cnt)));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ready |=> (cnt <= $past(cnt)));

  a_r9_reexec_no_squash: assert property (@(posedge clk) disable iff (!rst_n)
    !(REEXEC && sq_valid));
endmodule

// File: tb/spec_load_snoop_bench.sv
module spec_load_snoop_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, ld_valid, ret_valid, snp_valid;
  logic [15:0] ld_addr, snp_addr;
  logic [3:0]  ld_tag;
  logic        ld_ready, sq_valid, rx_valid;
  logic [3:0]  sq_tag, rx_tag;
  logic [15:0] rx_addr;
  logic        x_ready, x_sq, x_rx;
  logic [3:0]  x_sqtag, x_rxtag;
  logic [15:0] x_rxaddr;

  spec_load_snoop #(.ADDR_W(16), .TAG_W(4), .DEPTH(4), .LINE_OFF(6), .REEXEC(1'b0)) u_spec_load_snoop (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_tag(ld_tag),
    .ld_ready(ld_ready), .ret_valid(ret_valid), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .sq_valid(sq_valid), .sq_tag(sq_tag), .rx_valid(rx_valid), .rx_tag(rx_tag), .rx_addr(rx_addr));

  spec_load_snoop #(.ADDR_W(16), .TAG_W(4), .DEPTH(4), .LINE_OFF(6), .REEXEC(1'b1)) u_spec_load_snoop_rx (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_tag(ld_tag),
    .ld_ready(x_ready), .ret_valid(ret_valid), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .sq_valid(x_sq), .sq_tag(x_sqtag), .rx_valid(x_rx), .rx_tag(x_rxtag), .rx_addr(x_rxaddr));

  int total = 0;
  int bad = 0;

  typedef struct packed {
    logic        ldv;
    logic [15:0] la;
    logic [3:0]  lt;
    logic        ret;
    logic        snv;
    logic [15:0] sa;
    logic        esq;
    logic [3:0]  et;
    logic        erdy;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b1,16'h0100,4'd1,1'b0,1'b0,16'h0000,1'b0,4'd0,1'b1,4'd2},  // R2 insert
    '{1'b0,16'h0000,4'd0,1'b0,1'b1,16'h0110,1'b1,4'd1,1'b1,4'd3},  // R3 same line, other offset
    '{1'b1,16'h0100,4'd2,1'b0,1'b0,16'h0000,1'b0,4'd0,1'b1,4'd2},
    '{1'b0,16'h0000,4'd0,1'b0,1'b1,16'h0140,1'b0,4'd0,1'b1,4'd3},  // R3 next line misses
    '{1'b1,16'h0200,4'd3,1'b0,1'b0,16'h0000,1'b0,4'd0,1'b1,4'd7},
    '{1'b1,16'h0300,4'd4,1'b0,1'b0,16'h0000,1'b0,4'd0,1'b1,4'd7},
    '{1'b1,16'h0208,4'd5,1'b0,1'b0,16'h0000,1'b0,4'd0,1'b0,4'd7},  // R7 full
    '{1'b1,16'h0400,4'd6,1'b0,1'b0,16'h0000,1'b0,4'd0,1'b0,4'd7},  // R7 insert discarded
    '{1'b0,16'h0000,4'd0,1'b0,1'b1,16'h0400,1'b0,4'd0,1'b0,4'd7},  // R7 no trace of it
    '{1'b0,16'h0000,4'd0,1'b0,1'b1,16'h0220,1'b1,4'd3,1'b1,4'd4},  // R4 oldest of two
    '{1'b0,16'h0000,4'd0,1'b0,1'b1,16'h0300,1'b0,4'd0,1'b1,4'd5},  // R5 younger flushed
    '{1'b0,16'h0000,4'd0,1'b0,1'b1,16'h0100,1'b1,4'd2,1'b1,4'd5},  // R5 older kept
    '{1'b1,16'h0500,4'd7,1'b0,1'b0,16'h0000,1'b0,4'd0,1'b1,4'd6},
    '{1'b1,16'h0600,4'd8,1'b0,1'b0,16'h0000,1'b0,4'd0,1'b1,4'd6},
    '{1'b0,16'h0000,4'd0,1'b1,1'b1,16'h0500,1'b0,4'd0,1'b1,4'd6},  // R6 retiring not compared
    '{1'b0,16'h0000,4'd0,1'b0,1'b1,16'h0500,1'b0,4'd0,1'b1,4'd6},  // R6 retired gone
    '{1'b0,16'h0000,4'd0,1'b1,1'b0,16'h0000,1'b0,4'd0,1'b1,4'd6},
    '{1'b0,16'h0000,4'd0,1'b1,1'b0,16'h0000,1'b0,4'd0,1'b1,4'd6},  // R6 retire on empty
    '{1'b1,16'h0700,4'd9,1'b0,1'b0,16'h0000,1'b0,4'd0,1'b1,4'd8},
    '{1'b1,16'h0800,4'd10,1'b0,1'b1,16'h0800,1'b0,4'd0,1'b1,4'd8}, // R8 insert not compared
    '{1'b0,16'h0000,4'd0,1'b0,1'b1,16'h0800,1'b1,4'd10,1'b1,4'd8}, // R8 but stored
    '{1'b1,16'h0900,4'd11,1'b0,1'b1,16'h0700,1'b1,4'd9,1'b1,4'd8}, // R8 insert dropped by flush
    '{1'b0,16'h0000,4'd0,1'b0,1'b1,16'h0900,1'b0,4'd0,1'b1,4'd8}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ld_valid = 1'b0; ld_addr = '0; ld_tag = '0;
    ret_valid = 1'b0; snp_valid = 1'b0; snp_addr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ld_ready", 32'(ld_ready), 32'd1);
    chk("R1 sq_valid", 32'(sq_valid), 32'd0);
    chk("R1 rx_valid", 32'(x_rx), 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    do_reset();

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      ld_valid = VEC[k].ldv; ld_addr = VEC[k].la; ld_tag = VEC[k].lt;
      ret_valid = VEC[k].ret; snp_valid = VEC[k].snv; snp_addr = VEC[k].sa;
      @(posedge clk);
      #1;
      chk($sformatf("R%0d step %0d sq_valid", VEC[k].req, k), 32'(sq_valid), 32'(VEC[k].esq));
      chk($sformatf("R%0d step %0d sq_tag", VEC[k].req, k), 32'(sq_tag), 32'(VEC[k].et));
      chk($sformatf("R%0d step %0d ld_ready", VEC[k].req, k), 32'(ld_ready), 32'(VEC[k].erdy));
      chk($sformatf("R9 step %0d reexec sq_valid", k), 32'(x_sq), 32'd0);
    end

    // R9: re-execute mode announces retiring loads
    do_reset();
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = 16'h0104; ld_tag = 4'd1;
    @(negedge clk);
    ld_addr = 16'h0208; ld_tag = 4'd2;
    @(negedge clk);
    idle();
    snp_valid = 1'b1; snp_addr = 16'h0100;
    @(posedge clk);
    #1;
    chk("R9 snoop ignored", 32'(x_sq), 32'd0);
    @(negedge clk);
    idle();
    #1;
    chk("R9 no retire no rx", 32'(x_rx), 32'd0);
    ret_valid = 1'b1;
    #1;
    chk("R9 rx_valid first", 32'(x_rx), 32'd1);
    chk("R9 rx_tag first", 32'(x_rxtag), 32'd1);
    chk("R9 rx_addr first", 32'(x_rxaddr), 32'h0104);
    @(negedge clk);
    #1;
    chk("R9 rx_valid second", 32'(x_rx), 32'd1);
    chk("R9 rx_tag second", 32'(x_rxtag), 32'd2);
    chk("R9 rx_addr second", 32'(x_rxaddr), 32'h0208);
    @(negedge clk);
    #1;
    chk("R9 rx on empty", 32'(x_rx), 32'd0);
    chk("R9 snoop copy no rx", 32'(rx_valid), 32'd0);
    idle();

    // R7: refill to full after reset
    do_reset();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ld_valid = 1'b1; ld_addr = 16'(k * 64); ld_tag = 4'(k);
    end
    @(negedge clk);
    idle();
    #1;
    chk("R7 full after four", 32'(ld_ready), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule